// File: doc/BRIEF.md
# Configurable Pixel Unpacker

The block takes 32-bit frame-buffer words and splits each into a run of pixels, one per clock. Its output is either a palette index (for depths up to 8 bits) or a direct colour triple with 8 bits per component. A 3-bit depth code selects the pixel size. Two order flags choose how pixels sit in the word. A swap flag exchanges red and blue. A 2-bit format select, driven from outside, picks the 16-bit layout on the basic variant.

Both the word input and the pixel output use a valid/ready handshake. A word is held until its last pixel has been taken. The block also reports, from a column count, how many source bytes one display line occupies at the selected depth. Configuration inputs are expected to stay constant while a word is in flight.

Top module: `pixel_unpacker`

## Requirements
- R1: Depth codes 0..7 select 1, 2, 4, 8, 16 (5551), 24-in-32, 16 (565) and 12 bits per pixel. A word yields 32, 16, 8, 4, 2, 1, 2 and 2 pixels for these codes; the 12-bit mode uses a 16-bit container.
- R2: `line_bytes` equals cols/8, cols/4, cols/2 and cols for codes 0..3. It equals cols*2 for codes 4, 6 and 7, and cols*4 for code 5.
- R3: With both order flags clear, pixels come out from bit 0 upward: pixel k occupies bits [k*w +: w].
- R4: With only the pixel-order flag set, bytes are taken from byte 0 upward. Sub-byte pixels within each byte start at the most significant end. Pixels of 8 bits or more follow the R3 order.
- R5: With the byte-order flag set, the whole word is read from bit 31 downward: pixel k occupies bits [32-(k+1)*w +: w]. This flag wins over the pixel-order flag.
- R6: For codes 0..3, `out_is_index` is 1 and `out_index` carries the pixel zero-extended. For codes 4..7, `out_is_index` is 0.
- R7: In 5551 layout, red is bits 4:0, green bits 9:5 and blue bits 14:10; bit 15 is ignored. A 5-bit value c expands to {c, c[4:2]}.
- R8: In 565 layout, red is bits 4:0, green bits 10:5 and blue bits 15:11. A 6-bit value c expands to {c, c[5:4]}.
- R9: In 12-bit mode, red is bits 3:0, green 7:4 and blue 11:8, and bits 15:12 are ignored; a nibble c expands to {c, c}. In 24-in-32 mode, red is bits 7:0, green 15:8 and blue 23:16, and the top byte is ignored.
- R10: The swap flag exchanges red and blue on direct-colour output.
- R11: On the basic variant with code 4, format select 1 keeps 5551. Select 3 gives 565 with red and blue swapped whatever the swap flag says. Selects 0 and 2 give 565 and follow the swap flag.
- R12: `in_ready` is 1 when no word is held, or when the last pixel of the held word is being taken in the same cycle. While `out_valid` is 1 and `out_ready` is 0, the output holds and no word is accepted.
- R13: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_depth | input | 3 | Depth code |
| cfg_be_byte | input | 1 | Whole-word most-significant-first order |
| cfg_be_pix | input | 1 | Sub-byte pixels most-significant-first |
| cfg_bgr | input | 1 | Swap red and blue |
| cfg_fmt_sel | input | 2 | External 16-bit layout select |
| cfg_cols | input | COL_W | Pixels per display line |
| in_word | input | WORD_W | Frame-buffer word |
| in_valid | input | 1 | Word valid |
| in_ready | output | 1 | Word accepted when high with in_valid |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel taken when high with out_valid |
| out_is_index | output | 1 | Pixel is a palette index |
| out_index | output | COMP_W | Palette index |
| out_r | output | COMP_W | Red component |
| out_g | output | COMP_W | Green component |
| out_b | output | COMP_W | Blue component |
| line_bytes | output | COL_W+2 | Source bytes per display line |

## Verification
A wrong slot counter shows up at once on the pixel port. The count of pixels drawn from one word changes, or the wrong field appears within a cycle of the bad count. A broken end-of-word test makes `in_ready` rise early, dropping pixels, or stay low, hanging the stream; the second word after a stall exposes either case. Layout or swap errors affect only the colour bytes, so each layout is checked with known words whose components all differ.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

   typedef enum logic [2:0] {
      PXU_D1       = 3'd0,
      PXU_D2       = 3'd1,
      PXU_D4       = 3'd2,
      PXU_D8       = 3'd3,
      PXU_D16_5551 = 3'd4,
      PXU_D24      = 3'd5,
      PXU_D16_565  = 3'd6,
      PXU_D12      = 3'd7
   } pxu_depth_e;

   typedef enum logic [1:0] {
      PXU_ORD_LE     = 2'd0,
      PXU_ORD_BEPIX  = 2'd1,
      PXU_ORD_BEBYTE = 2'd2
   } pxu_order_e;

   typedef enum logic [1:0] {
      PXU_FMT_5551 = 2'd0,
      PXU_FMT_565  = 2'd1,
      PXU_FMT_444  = 2'd2,
      PXU_FMT_888  = 2'd3
   } pxu_fmt_e;

   // log2 of the container width in bits
   function automatic logic [2:0] pxu_lg_bits(input pxu_depth_e d);
      case (d)
         PXU_D1:  return 3'd0;
         PXU_D2:  return 3'd1;
         PXU_D4:  return 3'd2;
         PXU_D8:  return 3'd3;
         PXU_D24: return 3'd5;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [7:0] pxu_exp4(input logic [3:0] c);
      return {c, c};
   endfunction

   function automatic logic [7:0] pxu_exp5(input logic [4:0] c);
      return {c, c[4:2]};
   endfunction

   function automatic logic [7:0] pxu_exp6(input logic [5:0] c);
      return {c, c[5:4]};
   endfunction

endpackage

// File: rtl/pxu_slot_pick.sv
module pxu_slot_pick
   import pxu_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int SLOT_W = 5
) (
   input  logic [WORD_W-1:0] word,
   input  logic [2:0]        lg,
   input  logic [SLOT_W-1:0] slot,
   input  pxu_order_e        order,
   output logic [WORD_W-1:0] field
);
   localparam int POS_W = SLOT_W + 1;

   logic [POS_W-1:0]  wid;
   logic [POS_W-1:0]  off;
   logic [POS_W-1:0]  pos;
   logic [WORD_W-1:0] mask;

   always_comb begin
      wid = POS_W'(1) << lg;
      off = POS_W'(slot) << lg;
      case (order)
         PXU_ORD_BEBYTE: pos = POS_W'(WORD_W) - off - wid;
         PXU_ORD_BEPIX: begin
            if (lg < 3'd3)
               pos = (off & ~POS_W'(7)) + (POS_W'(8) - wid) - (off & POS_W'(7));
            else
               pos = off;
         end
         default: pos = off;
      endcase
      if (int'(lg) >= SLOT_W)
         mask = '1;
      else
         mask = (WORD_W'(1) << wid) - WORD_W'(1);
      field = (word >> pos) & mask;
   end

endmodule

// File: rtl/pxu_color_conv.sv
module pxu_color_conv
   import pxu_pkg::*;
#(
   parameter int WORD_W        = 32,
   parameter int COMP_W        = 8,
   parameter bit BASIC_VARIANT = 1'b1
) (
   input  logic [WORD_W-1:0] raw,
   input  pxu_depth_e        depth,
   input  logic              bgr,
   input  logic [1:0]        fmt_sel,
   output logic              is_index,
   output logic [COMP_W-1:0] index,
   output logic [COMP_W-1:0] r,
   output logic [COMP_W-1:0] g,
   output logic [COMP_W-1:0] b
);
   pxu_fmt_e   fmt16;
   logic       swap16;
   pxu_fmt_e   fmt;
   logic       swap;
   logic [7:0] cr, cg, cb;

   generate
      if (BASIC_VARIANT) begin : g_mux16
         always_comb begin
            case (fmt_sel)
               2'd1:    begin fmt16 = PXU_FMT_5551; swap16 = bgr;  end
               2'd3:    begin fmt16 = PXU_FMT_565;  swap16 = 1'b1; end
               default: begin fmt16 = PXU_FMT_565;  swap16 = bgr;  end
            endcase
         end
      end else begin : g_fixed16
         always_comb begin
            fmt16  = PXU_FMT_5551;
            swap16 = bgr;
         end
      end
   endgenerate

   always_comb begin
      swap = bgr;
      case (depth)
         PXU_D16_5551: begin fmt = fmt16; swap = swap16; end
         PXU_D16_565:  fmt = PXU_FMT_565;
         PXU_D12:      fmt = PXU_FMT_444;
         PXU_D24:      fmt = PXU_FMT_888;
         default:      fmt = PXU_FMT_5551;
      endcase

      case (fmt)
         PXU_FMT_565: begin
            cr = pxu_exp5(raw[4:0]);
            cg = pxu_exp6(raw[10:5]);
            cb = pxu_exp5(raw[15:11]);
         end
         PXU_FMT_444: begin
            cr = pxu_exp4(raw[3:0]);
            cg = pxu_exp4(raw[7:4]);
            cb = pxu_exp4(raw[11:8]);
         end
         PXU_FMT_888: begin
            cr = raw[7:0];
            cg = raw[15:8];
            cb = raw[23:16];
         end
         default: begin
            cr = pxu_exp5(raw[4:0]);
            cg = pxu_exp5(raw[9:5]);
            cb = pxu_exp5(raw[14:10]);
         end
      endcase

      is_index = (depth <= PXU_D8);
      index    = raw[COMP_W-1:0];
      r        = swap ? cb : cr;
      g        = cg;
      b        = swap ? cr : cb;
   end

endmodule

// File: rtl/pxu_line_calc.sv
module pxu_line_calc
   import pxu_pkg::*;
#(
   parameter int COL_W = 12
) (
   input  logic [COL_W-1:0] cols,
   input  pxu_depth_e       depth,
   output logic [COL_W+1:0] line_bytes
);
   localparam int LB_W = COL_W + 2;

   logic [LB_W-1:0] c;

   always_comb begin
      c = LB_W'(cols);
      case (depth)
         PXU_D1:  line_bytes = c >> 3;
         PXU_D2:  line_bytes = c >> 2;
         PXU_D4:  line_bytes = c >> 1;
         PXU_D8:  line_bytes = c;
         PXU_D24: line_bytes = c << 2;
         default: line_bytes = c << 1;
      endcase
   end

endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
   import pxu_pkg::*;
#(
   parameter int WORD_W        = 32,
   parameter int COMP_W        = 8,
   parameter int COL_W         = 12,
   parameter bit BASIC_VARIANT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_depth,
   input  logic              cfg_be_byte,
   input  logic              cfg_be_pix,
   input  logic              cfg_bgr,
   input  logic [1:0]        cfg_fmt_sel,
   input  logic [COL_W-1:0]  cfg_cols,
   input  logic [WORD_W-1:0] in_word,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_is_index,
   output logic [COMP_W-1:0] out_index,
   output logic [COMP_W-1:0] out_r,
   output logic [COMP_W-1:0] out_g,
   output logic [COMP_W-1:0] out_b,
   output logic [COL_W+1:0]  line_bytes
);
   localparam int SLOT_W = $clog2(WORD_W);

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("pixel_unpacker: WORD_W must be 32");
      end
      if (COMP_W != 8) begin : g_bad_comp
         $error("pixel_unpacker: COMP_W must be 8");
      end
      if (COL_W < 4) begin : g_bad_cols
         $error("pixel_unpacker: COL_W too small");
      end
   endgenerate

   pxu_depth_e        depth;
   pxu_order_e        order;
   logic [2:0]        lg;
   logic [SLOT_W-1:0] slot_max;
   logic [SLOT_W-1:0] slot_q;
   logic [WORD_W-1:0] word_q;
   logic              full_q;
   logic              is_last;
   logic              take_in;
   logic              take_out;
   logic [WORD_W-1:0] field;

   always_comb begin
      depth    = pxu_depth_e'(cfg_depth);
      lg       = pxu_lg_bits(depth);
      slot_max = SLOT_W'((WORD_W >> lg) - 1);
      if (cfg_be_byte)     order = PXU_ORD_BEBYTE;
      else if (cfg_be_pix) order = PXU_ORD_BEPIX;
      else                 order = PXU_ORD_LE;
      is_last  = (slot_q == slot_max);
      take_out = full_q & out_ready;
      in_ready = ~full_q | (is_last & out_ready);
      take_in  = in_valid & in_ready;
      out_valid = full_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         slot_q <= '0;
         word_q <= '0;
      end else if (take_in) begin
         full_q <= 1'b1;
         slot_q <= '0;
         word_q <= in_word;
      end else if (take_out) begin
         if (is_last) full_q <= 1'b0;
         else         slot_q <= slot_q + SLOT_W'(1);
      end
   end

   pxu_slot_pick #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) pick_i (
      .word  (word_q),
      .lg    (lg),
      .slot  (slot_q),
      .order (order),
      .field (field)
   );

   pxu_color_conv #(.WORD_W(WORD_W), .COMP_W(COMP_W),
                    .BASIC_VARIANT(BASIC_VARIANT)) conv_i (
      .raw      (field),
      .depth    (depth),
      .bgr      (cfg_bgr),
      .fmt_sel  (cfg_fmt_sel),
      .is_index (out_is_index),
      .index    (out_index),
      .r        (out_r),
      .g        (out_g),
      .b        (out_b)
   );

   pxu_line_calc #(.COL_W(COL_W)) line_i (
      .cols       (cfg_cols),
      .depth      (depth),
      .line_bytes (line_bytes)
   );

endmodule

// File: rtl/pixel_unpacker_chk.sv
module pixel_unpacker_chk #(
   parameter int COMP_W = 8,
   parameter int COL_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cfg_depth,
   input logic [1:0]        cfg_fmt_sel,
   input logic [COL_W-1:0]  cfg_cols,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic              out_is_index,
   input logic [COMP_W-1:0] out_index,
   input logic [COMP_W-1:0] out_r,
   input logic [COMP_W-1:0] out_g,
   input logic [COMP_W-1:0] out_b,
   input logic [COL_W+1:0]  line_bytes
);
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_index) && $stable(out_r)
                                     && $stable(out_g) && $stable(out_b))); // R12
   AST_NO_ACCEPT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R12
   AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready); // R13
   AST_LINE_BYTES_D8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_depth == 3'd3) |-> (line_bytes == (COL_W+2)'(cfg_cols))); // R2
   AST_LINE_BYTES_D32: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_depth == 3'd5) |-> (line_bytes == ((COL_W+2)'(cfg_cols) << 2))); // R2
   AST_INDEX_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_is_index == (cfg_depth < 3'd4))); // R6
   AST_INDEX_1BPP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg_depth == 3'd0) |-> (out_index[7:1] == 7'd0)); // R1
   AST_EXPAND_12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg_depth == 3'd7) |-> (out_g[7:4] == out_g[3:0])); // R9
   AST_EXPAND_5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg_depth == 3'd4 && cfg_fmt_sel == 2'd1)
      |-> (out_g[2:0] == out_g[7:5])); // R7
endmodule

bind pixel_unpacker pixel_unpacker_chk #(.COMP_W(COMP_W), .COL_W(COL_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_depth    (cfg_depth),
   .cfg_fmt_sel  (cfg_fmt_sel),
   .cfg_cols     (cfg_cols),
   .in_ready     (in_ready),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_is_index (out_is_index),
   .out_index    (out_index),
   .out_r        (out_r),
   .out_g        (out_g),
   .out_b        (out_b),
   .line_bytes   (line_bytes)
);

// File: tb/pixel_unpacker_tb_top.sv
module pixel_unpacker_tb_top;
   localparam int COL_W = 12;
   localparam logic [31:0] WORD = 32'hC6A5_3E91;
   localparam int NVEC = 20;
   // {depth, flags(beb,bep,bgr,isidx), sel, pad, slot, idx, r, g, b, pad}
   localparam logic [63:0] VEC [NVEC] = '{
      64'h0_1_1_0_00_01_00_00_00_00,
      64'h0_5_1_0_03_01_00_00_00_00,
      64'h0_5_1_0_01_00_00_00_00_00,
      64'h0_9_1_0_02_00_00_00_00_00,
      64'h0_D_1_0_01_01_00_00_00_00,
      64'h1_1_1_0_04_02_00_00_00_00,
      64'h1_5_1_0_04_00_00_00_00_00,
      64'h2_9_1_0_01_06_00_00_00_00,
      64'h3_5_1_0_02_A5_00_00_00_00,
      64'h3_9_1_0_02_3E_00_00_00_00,
      64'h4_0_1_0_00_00_8C_A5_7B_00,
      64'h4_2_1_0_00_00_7B_A5_8C_00,
      64'h4_0_3_0_00_00_39_D3_8C_00,
      64'h4_0_2_0_00_00_8C_D3_39_00,
      64'h4_2_0_0_00_00_39_D3_8C_00,
      64'h6_0_1_0_01_00_29_D7_C6_00,
      64'h7_0_1_0_00_00_11_99_EE_00,
      64'h5_0_1_0_00_00_91_3E_A5_00,
      64'h5_2_1_0_00_00_A5_3E_91_00,
      64'h4_8_1_0_00_00_29_AD_8C_00
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] cfg_depth = '0;
   logic cfg_be_byte = 1'b0, cfg_be_pix = 1'b0, cfg_bgr = 1'b0;
   logic [1:0] cfg_fmt_sel = 2'd1;
   logic [COL_W-1:0] cfg_cols = '0;
   logic [31:0] in_word = '0;
   logic in_valid = 1'b0;
   logic in_ready, out_valid, out_is_index;
   logic out_ready = 1'b0;
   logic [7:0] out_index, out_r, out_g, out_b;
   logic [COL_W+1:0] line_bytes;

   int n_checks = 0;
   int n_errors = 0;
   int npix;
   logic [7:0] cap_idx [32];
   logic [7:0] cap_r [32];
   logic [7:0] cap_g [32];
   logic [7:0] cap_b [32];
   logic       cap_isx [32];

   always #10 clk = ~clk;

   pixel_unpacker #(.COL_W(COL_W)) dut_i (.*);

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] w);
      @(negedge clk);
      in_word  = w;
      in_valid = 1'b1;
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic drain();
      npix = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!out_valid) break;
         if (npix < 32) begin
            cap_idx[npix] = out_index;
            cap_r[npix]   = out_r;
            cap_g[npix]   = out_g;
            cap_b[npix]   = out_b;
            cap_isx[npix] = out_is_index;
         end
         out_ready = 1'b1;
         @(posedge clk);
         #1 out_ready = 1'b0;
         npix++;
      end
   endtask

   function automatic int pix_per_word(input logic [2:0] d);
      case (d)
         3'd0: return 32;
         3'd1: return 16;
         3'd2: return 8;
         3'd3: return 4;
         3'd5: return 1;
         default: return 2;
      endcase
   endfunction

   function automatic string tag_of(input logic [63:0] v);
      logic [2:0] d;
      d = v[62:60];
      if (d < 3'd4) return v[59] ? "R5" : (v[58] ? "R4" : "R3");
      if (d == 3'd4 && v[53:52] != 2'd1) return "R11";
      if (v[57]) return "R10";
      if (d == 3'd4) return "R7";
      if (d == 3'd6) return "R8";
      return "R9";
   endfunction

   initial begin
      #2000000;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13: reset state
      check("R13", "out_valid in reset", 32'(out_valid), 32'd0);
      check("R13", "in_ready in reset", 32'(in_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R13", "out_valid after reset", 32'(out_valid), 32'd0);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         int slot;
         cfg_depth   = VEC[v][62:60];
         cfg_be_byte = VEC[v][59];
         cfg_be_pix  = VEC[v][58];
         cfg_bgr     = VEC[v][57];
         cfg_fmt_sel = VEC[v][53:52];
         slot        = int'(VEC[v][47:40]);
         push(WORD);
         drain();
         check("R1", $sformatf("vec %0d pixel count", v), 32'(npix),
               32'(pix_per_word(cfg_depth)));
         check("R6", $sformatf("vec %0d index flag", v), 32'(cap_isx[slot]),
               32'(VEC[v][56]));
         if (VEC[v][56]) begin
            check(tag_of(VEC[v]), $sformatf("vec %0d index", v),
                  32'(cap_idx[slot]), 32'(VEC[v][39:32]));
         end else begin
            check(tag_of(VEC[v]), $sformatf("vec %0d rgb", v),
                  {8'h0, cap_r[slot], cap_g[slot], cap_b[slot]},
                  {8'h0, VEC[v][31:8]});
         end
      end

      // R2: line byte count for every depth, cols = 640
      cfg_cols = 12'd640;
      for (int d = 0; d < 8; d++) begin
         int exp;
         cfg_depth = 3'(d);
         case (d)
            0: exp = 80;
            1: exp = 160;
            2: exp = 320;
            3: exp = 640;
            5: exp = 2560;
            default: exp = 1280;
         endcase
         #1 check("R2", $sformatf("line bytes depth %0d", d), 32'(line_bytes), 32'(exp));
      end

      // R12: stall holds output and refuses the next word
      cfg_depth = 3'd3; cfg_be_byte = 1'b0; cfg_be_pix = 1'b0;
      push(WORD);
      @(negedge clk);
      in_word  = 32'h1234_5678;
      in_valid = 1'b1;
      for (int s = 0; s < 3; s++) begin
         @(negedge clk);
         check("R12", "valid while stalled", 32'(out_valid), 32'd1);
         check("R12", "no accept while stalled", 32'(in_ready), 32'd0);
         check("R12", "index held while stalled", 32'(out_index), 32'h91);
      end
      for (int p = 0; p < 3; p++) begin
         @(negedge clk);
         out_ready = 1'b1;
         @(posedge clk);
         #1 out_ready = 1'b0;
      end
      @(negedge clk);
      check("R12", "last pixel before refill", 32'(out_index), 32'hC6);
      check("R12", "in_ready low at last pixel without out_ready", 32'(in_ready), 32'd0);
      out_ready = 1'b1;
      #1 check("R12", "in_ready at last pixel with out_ready", 32'(in_ready), 32'd1);
      @(posedge clk);
      #1 begin out_ready = 1'b0; in_valid = 1'b0; end
      @(negedge clk);
      check("R12", "next word first pixel", 32'(out_index), 32'h78);
      drain();
      check("R12", "remaining pixels of next word", 32'(npix), 32'd4);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule